// File: doc/BRIEF.md
# 64-bit System Tick Timer

This block is a free-running 64-bit tick counter meant to serve as the operating-system time base of a chip. It has a compare register and a match flag that drives an interrupt line. Count events come from one or more of three source strobes, chosen in a control register. A prescaler divides the selected strobes by 1, 4, 16, 64, 256 or 1024. The counter is enabled through a bit in shared enable-set and enable-clear registers, and a halt bit in the control register freezes it.

The count is read over a 32-bit register bus as two halves. A read of the low half also copies the high half, taken in the same cycle, into a shadow register. Software reads the low half first and the shadow second, so it always gets a coherent 64-bit value even while the counter runs. A mode bit decides what happens when the low half matches the compare value: the whole counter clears to zero, or it keeps running. In both modes a match raises the flag.

Top module: `sys_tick64`

## Requirements
- R1: The register offsets on bus_addr are: 0 compare, 1 count low half, 2 count high half, 3 control, 4 high-half shadow, 5 enable set / enable status, 6 enable clear, 7 flag status, 8 flag clear. Read data appears on bus_rdata one cycle after bus_rd is sampled high. Any other offset reads as zero.
- R2: After reset every register reads zero and irq is low.
- R3: The counter advances only when two conditions hold. First, the enable state is 1; writing bit 15 = 1 to offset 5 sets it, writing bit 15 = 1 to offset 6 clears it, and it reads back as bit 15 at offset 5. Second, a src_tick bit is high whose select bit is set, where control bits 2:0 select src_tick[2:0].
- R4: Control bits 5:3 set the prescale. Values 0, 1, 2, 3 and 4 give one count per 1, 4, 16, 64 and 256 selected source strobes. Values 5, 6 and 7 give one count per 1024.
- R5: While control bit 9 is 1, the prescaler and the counter hold their values.
- R6: The two halves advance as one 64-bit value. A count from low half 0xFFFFFFFF gives low half 0 and increments the high half in the same cycle.
- R7: A read of offset 1 loads the current high half into the shadow at offset 4. The shadow keeps that value, even if the high half changes, until the next read of offset 1.
- R8: A count taken while the low half equals the compare value has an effect that depends on control bit 15. When bit 15 is 0, the whole 64-bit counter clears to zero. When bit 15 is 1, the counter increments as usual.
- R9: The count described in R8 sets the flag in either mode. The flag reads as bit 15 at offset 7 and drives irq high. Writing bit 15 = 1 to offset 8 clears the flag, but a match in the same cycle wins.
- R10: Writes to offsets 1 and 2 load the matching half of the counter and take priority over a count in the same cycle. The control register keeps only bits 2:0, 5:3, 9 and 15; all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| src_tick | input | 3 | Count source strobes, one cycle each |
| irq | output | 1 | Match flag |

## Verification
The assertions check the following on every cycle. A count never happens while the timer is disabled or halted. The counter only changes on a count or a software write. A carry from the low half moves exactly one into the high half. A match clears the counter in wrap mode and always leaves the flag set. The shadow changes only on a low-half read, and then takes the high half from that cycle.

Some behaviour only the bench scenarios can show: the exact prescale ratio for each code, the period of the wrap mode for a given compare value, that the shadow keeps an old value after a later write to the high half, the control readback mask, and that a write wins over a count in the same cycle.

// File: rtl/tick64_pkg.sv
// Package shared by the 64-bit tick timer: register offsets, control
// bit positions and the prescale limit decode.
package tick64_pkg;

    localparam int ADDR_W = 4;
    localparam int PRE_W  = 10;

    localparam logic [ADDR_W-1:0] OFS_CMP      = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO   = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI   = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_SHADOW   = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_FLAG     = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_FLAG_CLR = 4'd8;

    // Bit that neighbouring shared registers decode for this timer.
    localparam int UNIT_BIT = 15;
    localparam int KEEP_BIT = 15;
    localparam int HALT_BIT = 9;

    typedef logic [PRE_W-1:0] pre_t;

    typedef struct packed {
        logic       keep_run;
        logic       halt;
        logic [2:0] div_sel;
        logic [2:0] src_en;
    } ctrl_t;

    // Terminal prescaler value for a divide code.
    function automatic pre_t div_limit(input logic [2:0] sel);
        case (sel)
            3'd0:    div_limit = pre_t'(0);
            3'd1:    div_limit = pre_t'(3);
            3'd2:    div_limit = pre_t'(15);
            3'd3:    div_limit = pre_t'(63);
            3'd4:    div_limit = pre_t'(255);
            default: div_limit = pre_t'(1023);
        endcase
    endfunction

endpackage

// File: rtl/tick64_prescaler.sv
// Prescaler: counts selected source strobes and emits a one-cycle count
// tick every 1..1024 strobes. It holds its state while run is low.
// Assumes src_hit is a single-cycle strobe that is already synchronous.
module tick64_prescaler
    import tick64_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       src_hit,
    input  logic [2:0] div_sel,
    output logic       tick
);

    pre_t pre_q;
    pre_t lim;

    // Terminal value of the selected divide ratio.
    always_comb lim = div_limit(div_sel);

    // Emit a count on the strobe that reaches the terminal value.
    always_comb tick = run && src_hit && (pre_q >= lim);

    // Advance the strobe count, wrapping at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (run && src_hit)
            pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
    end

endmodule

// File: rtl/tick64_counter.sv
// Two-half counter with compare. Both halves update in one register stage,
// so a carry never shows as a torn value. Software writes to either half
// win over a tick in the same cycle.
module tick64_counter #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                keep_run,
    input  logic [DATA_W-1:0]   cmp,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] cnt,
    output logic                match
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;
    logic             sw_load;

    // A software load suppresses a count in the same cycle.
    always_comb sw_load = wr_lo || wr_hi;

    // Match is a count taken while the low half equals the compare value.
    always_comb match = tick && !sw_load && (cnt_q[DATA_W-1:0] == cmp);

    // Load, clear on match or increment the full count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sw_load) begin
            if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (tick) begin
            if (match && !keep_run)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/sys_tick64.sv
// Top of the 64-bit system tick timer: register decode, enable and flag
// state, the high-half shadow and the registered read path. Assumes a
// single-cycle bus with reads answered on the following cycle.
module sys_tick64
    import tick64_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [2:0]        src_tick,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] cmp_q;
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic [CNT_W-1:0]  cnt;
    logic              en_q;
    logic              flag_q;
    logic              tick;
    logic              match;
    logic              src_hit;
    logic              run;
    logic              wr_lo;
    logic              wr_hi;
    logic              cnt_wr;
    logic              rd_lo;

    // Write strobes for the count halves and the low-half read strobe.
    always_comb begin
        wr_lo  = bus_wr && (bus_addr == OFS_CNT_LO);
        wr_hi  = bus_wr && (bus_addr == OFS_CNT_HI);
        cnt_wr = wr_lo || wr_hi;
        rd_lo  = bus_rd && (bus_addr == OFS_CNT_LO);
    end

    // Any selected source strobe counts; the prescaler runs when enabled and not halted.
    always_comb begin
        src_hit = |(ctrl_q.src_en & src_tick);
        run     = en_q && !ctrl_q.halt;
    end

    tick64_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .src_hit (src_hit),
        .div_sel (ctrl_q.div_sel),
        .tick    (tick)
    );

    tick64_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .keep_run (ctrl_q.keep_run),
        .cmp      (cmp_q),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .match    (match)
    );

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (bus_wr && (bus_addr == OFS_CMP))
            cmp_q <= bus_wdata;
    end

    // Control register, keeping only its defined fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && (bus_addr == OFS_CTRL)) begin
            ctrl_q.src_en   <= bus_wdata[2:0];
            ctrl_q.div_sel  <= bus_wdata[5:3];
            ctrl_q.halt     <= bus_wdata[HALT_BIT];
            ctrl_q.keep_run <= bus_wdata[KEEP_BIT];
        end
    end

    // Enable state through the shared set and clear offsets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (bus_wr && (bus_addr == OFS_EN_SET) && bus_wdata[UNIT_BIT])
            en_q <= 1'b1;
        else if (bus_wr && (bus_addr == OFS_EN_CLR) && bus_wdata[UNIT_BIT])
            en_q <= 1'b0;
    end

    // Match flag: a match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (match)
            flag_q <= 1'b1;
        else if (bus_wr && (bus_addr == OFS_FLAG_CLR) && bus_wdata[UNIT_BIT])
            flag_q <= 1'b0;
    end

    // Shadow takes the high half on every low-half read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (rd_lo)
            shadow_q <= cnt[CNT_W-1:DATA_W];
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_CMP:    rd_mux = cmp_q;
            OFS_CNT_LO: rd_mux = cnt[DATA_W-1:0];
            OFS_CNT_HI: rd_mux = cnt[CNT_W-1:DATA_W];
            OFS_CTRL: begin
                rd_mux[2:0]      = ctrl_q.src_en;
                rd_mux[5:3]      = ctrl_q.div_sel;
                rd_mux[HALT_BIT] = ctrl_q.halt;
                rd_mux[KEEP_BIT] = ctrl_q.keep_run;
            end
            OFS_SHADOW: rd_mux = shadow_q;
            OFS_EN_SET: rd_mux[UNIT_BIT] = en_q;
            OFS_FLAG:   rd_mux[UNIT_BIT] = flag_q;
            default:    rd_mux = '0;
        endcase
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq       = flag_q;

endmodule

// File: rtl/sys_tick64_chk.sv
// Checker for the 64-bit tick timer, bound to the top module. It watches
// the count tick, the counter, the flag and the shadow on every cycle.
module sys_tick64_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                match,
    input logic                cnt_wr,
    input logic                rd_lo,
    input logic                en,
    input logic                halt,
    input logic                keep_run,
    input logic                flag,
    input logic [DATA_W-1:0]   cmp,
    input logic [DATA_W-1:0]   shadow,
    input logic [2*DATA_W-1:0] cnt
);

    localparam int CNT_W = 2 * DATA_W;

    AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick); // R3
    AST_NO_TICK_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !tick); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt)); // R3
    AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && (cnt[DATA_W-1:0] == '1) && (keep_run || cmp != '1))
        |=> (cnt[DATA_W-1:0] == '0) && (cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W]) + 1'b1)); // R6
    AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !keep_run && cnt[DATA_W-1:0] == cmp) |=> (cnt == '0)); // R8
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag); // R9
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> $stable(shadow)); // R7
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (shadow == $past(cnt[CNT_W-1:DATA_W]))); // R7

endmodule

bind sys_tick64 sys_tick64_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .match    (match),
    .cnt_wr   (cnt_wr),
    .rd_lo    (rd_lo),
    .en       (en_q),
    .halt     (ctrl_q.halt),
    .keep_run (ctrl_q.keep_run),
    .flag     (flag_q),
    .cmp      (cmp_q),
    .shadow   (shadow_q),
    .cnt      (cnt)
);

// File: tb/sys_tick64_bench.sv
`timescale 1ns/1ps
module sys_tick64_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  src_tick = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [3:0] A_CMP = 4'd0, A_LO = 4'd1, A_HI = 4'd2, A_CTRL = 4'd3,
                           A_SHD = 4'd4, A_ENS = 4'd5, A_ENC = 4'd6, A_FLG = 4'd7,
                           A_FLC = 4'd8;
    localparam logic [31:0] B15 = 32'h0000_8000;

    always #2.5 clk = ~clk;

    sys_tick64 u_sys_tick64 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic strobe(input logic [2:0] m, input int n);
        @(negedge clk);
        src_tick = m;
        repeat (n) @(negedge clk);
        src_tick = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v);
            check("R2 reset readback", v, 32'h0);
        end
        check("R2 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(A_CMP, 32'd1000);
        wr(A_CTRL, 32'h0000_8001);
        strobe(3'b001, 5);
        rd(A_LO, v); check("R3 disabled holds", v, 32'd0);
        wr(A_ENS, B15);
        rd(A_ENS, v); check("R3 enable status", v, B15);
        strobe(3'b001, 5);
        rd(A_LO, v); check("R3 counts selected source", v, 32'd5);
        strobe(3'b110, 4);
        rd(A_LO, v); check("R3 unselected source ignored", v, 32'd5);
        wr(A_ENC, B15);
        strobe(3'b001, 3);
        rd(A_LO, v); check("R3 cleared enable holds", v, 32'd5);
        wr(A_ENS, B15);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(A_LO, 32'd0);
        wr(A_CTRL, 32'h0000_8001 | (32'd1 << 3));
        strobe(3'b001, 12);
        rd(A_LO, v); check("R4 divide by 4", v, 32'd3);
        wr(A_CTRL, 32'h0000_8001 | (32'd2 << 3));
        strobe(3'b001, 32);
        rd(A_LO, v); check("R4 divide by 16", v, 32'd5);
        wr(A_CTRL, 32'h0000_8001 | (32'd5 << 3));
        strobe(3'b001, 2048);
        rd(A_LO, v); check("R4 divide by 1024", v, 32'd7);
        wr(A_CTRL, 32'h0000_8001 | (32'd7 << 3));
        strobe(3'b001, 1024);
        rd(A_LO, v); check("R4 code 7 divides by 1024", v, 32'd8);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        wr(A_CTRL, 32'h0000_8201);
        strobe(3'b001, 10);
        rd(A_LO, v); check("R5 halt holds count", v, 32'd8);
        wr(A_CTRL, 32'h0000_8001);
    endtask

    task automatic t_carry_shadow();
        logic [31:0] v;
        wr(A_HI, 32'd5);
        wr(A_LO, 32'hFFFF_FFFE);
        strobe(3'b001, 3);
        rd(A_LO, v); check("R6 low after carry", v, 32'd1);
        rd(A_SHD, v); check("R7 shadow after low read", v, 32'd6);
        wr(A_HI, 32'h77);
        rd(A_SHD, v); check("R7 shadow keeps old high", v, 32'd6);
        rd(A_HI, v); check("R10 high write loads", v, 32'h77);
        rd(A_LO, v);
        rd(A_SHD, v); check("R7 shadow reloads", v, 32'h77);
    endtask

    task automatic t_wrap_flag();
        logic [31:0] v;
        wr(A_FLC, B15);
        wr(A_CTRL, 32'h0000_0001);
        wr(A_CMP, 32'd4);
        wr(A_LO, 32'd0);
        wr(A_HI, 32'd0);
        strobe(3'b001, 5);
        rd(A_LO, v); check("R8 wrap to zero", v, 32'd0);
        rd(A_FLG, v); check("R9 flag on wrap match", v, B15);
        check("R9 irq on match", {31'b0, irq}, 32'd1);
        strobe(3'b001, 2);
        rd(A_LO, v); check("R8 restarts after wrap", v, 32'd2);
        wr(A_FLC, B15);
        rd(A_FLG, v); check("R9 flag cleared", v, 32'd0);
        check("R9 irq cleared", {31'b0, irq}, 32'd0);
        wr(A_CTRL, 32'h0000_8001);
        wr(A_LO, 32'd0);
        strobe(3'b001, 6);
        rd(A_LO, v); check("R8 keep running past match", v, 32'd6);
        rd(A_FLG, v); check("R9 flag in running mode", v, B15);
    endtask

    task automatic t_write_priority();
        logic [31:0] v;
        @(negedge clk);
        src_tick = 3'b001; bus_wr = 1'b1; bus_addr = A_LO; bus_wdata = 32'd100;
        @(negedge clk);
        src_tick = '0; bus_wr = 1'b0;
        rd(A_LO, v); check("R10 write wins over count", v, 32'd100);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R10 control mask", v, 32'h0000_823F);
        wr(A_CTRL, 32'h0000_8001);
        rd(4'd12, v); check("R1 unmapped offset", v, 32'd0);
        rd(A_CMP, v); check("R1 compare readback", v, 32'd4);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_prescale();
        t_halt();
        t_carry_shadow();
        t_wrap_flag();
        t_write_priority();
        finish_run();
    end

endmodule